// File: doc/BRIEF.md
# Sparse-Hit Event Block Framer

The framer turns the sparsified hits of one trigger into a self-describing event block in a 32-bit output FIFO that a host later drains. An accepted trigger opens an event. Hit words arriving after that point are held in an internal staging buffer until the end-of-frame marker. The framer then writes the block: two header words, the hits in arrival order, and one trailer word.

The header identifies the event and gives the total number of words in the block. For this reason the hits are staged before the header goes out. A trigger-busy output rises in the same cycle a trigger is accepted. A mode input selects when busy is released:
- after the host signals that it has drained the event, or
- directly after the trailer is written, so that the host's readout of one event overlaps the collection of the next.

The controller has seven named states:

| State | Action | Next state |
|---|---|---|
| IDLE | Waits for a trigger. | Goes to COLLECT when a trigger is accepted. |
| COLLECT | Stages hits. | Goes to HDR_EVT on end-of-frame. |
| HDR_EVT | Writes the event-number header word. | Goes to HDR_CNT. |
| HDR_CNT | Writes the word-count header word. | Goes to EMIT, or to TRAILER when no hit was staged. |
| EMIT | Writes one staged hit per cycle. | Goes to TRAILER after the last hit. |
| TRAILER | Writes the trailer word. | Goes to IDLE in overlap mode, to WAIT_DRAIN otherwise. |
| WAIT_DRAIN | Holds busy. | Goes to IDLE on the drain-complete signal. |

Top module: `zs_event_framer`

## Requirements
- R1: After reset, busy_o is 0, fifo_wr_o is 0, and the event number is 0.
- R2: A trigger in IDLE is accepted, and busy_o is 1 in that same cycle (the output is combinational from trig_i).
- R3: Hits are staged only from the cycle after acceptance up to and including the cycle that carries frame_end_i. Hits presented while no event is open are ignored.
- R4: The first word written begins in the cycle after end-of-frame. It is the event-number header: bits [31:24]=0xA5, bits [23:16]=0, bits [15:0]=event number.
- R5: The second word is the word-count header: bits [31:16]=0, bits [15:0]=number of staged hits + 3, which is the whole block length.
- R6: The staged hits follow on consecutive cycles, in arrival order and unchanged.
- R7: The last word is the trailer: bits [31:24]=0x5A, bits [23:16]=0, bits [15:0]=number of staged hits.
- R8: The event number grows by one after each trailer and wraps modulo 2^16.
- R9: With overlap_i=0 at the trailer cycle, busy_o stays 1 until host_drained_i is seen. It is 0 from the cycle after that.
- R10: With overlap_i=1 at the trailer cycle, busy_o is 0 in the next cycle, and a new trigger is accepted there.
- R11: A trigger that arrives while busy_o is already 1 is ignored and starts no event.
- R12: At most DEPTH hits are staged per event. Later hits are discarded, and both counts report only the staged hits.
- R13: An event with no hits yields exactly three words: the header, a count of 3, and a trailer with count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Trigger request |
| overlap_i | input | 1 | Busy release mode (1 = release after trailer) |
| hit_valid_i | input | 1 | Hit word valid |
| hit_data_i | input | 32 | Hit word |
| frame_end_i | input | 1 | End of the frame scan for the open event |
| host_drained_i | input | 1 | Host has read the event out of the FIFO |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 32 | FIFO write word |
| busy_o | output | 1 | Trigger busy |

## Verification
The directed tests cover several hit patterns:
- Three hits: checks framing and ordering.
- No hits: separates the empty-event path from the EMIT path.
- Twenty hits into a sixteen-entry buffer: exposes overflow handling.
- One hit whose frame end comes after a run of stray hits given before the trigger: shows whether unopened events leak into the buffer.

Across events, the header event number separates correct increment from a stuck or skipped counter. Each busy-release mode is tried: default mode with a trigger pulsed while waiting for the drain, and overlap mode with a second trigger issued the moment busy falls. These distinguish the two release points and the rejection of triggers while busy.

// File: rtl/zs_framer_pkg.sv
package zs_framer_pkg;

    localparam int WORD_W = 32;
    localparam int EVT_W  = 16;

    localparam logic [7:0] MARK_HDR = 8'hA5;
    localparam logic [7:0] MARK_TRL = 8'h5A;

    // number of non-hit words in a block (two header words and the trailer)
    localparam logic [15:0] FRAME_OVERHEAD = 16'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_COLLECT,
        S_HDR_EVT,
        S_HDR_CNT,
        S_EMIT,
        S_TRAILER,
        S_WAIT_DRAIN
    } fr_state_t;

    function automatic logic is_write_state(fr_state_t s);
        return (s == S_HDR_EVT) || (s == S_HDR_CNT) ||
               (s == S_EMIT)    || (s == S_TRAILER);
    endfunction

endpackage

// File: rtl/zs_hit_stage.sv
module zs_hit_stage
    import zs_framer_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] din_i,
    input  logic [CW-1:0]     rd_idx_i,
    output logic [WORD_W-1:0] dout_o,
    output logic [CW-1:0]     count_o
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [CW-1:0]     cnt_q;
    logic              room;

    assign room = (cnt_q < CW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (wr_i && room) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_i && room && !clr_i) begin
            mem[cnt_q[AW-1:0]] <= din_i;
        end
    end

    assign dout_o  = mem[rd_idx_i[AW-1:0]];
    assign count_o = cnt_q;

    // R12
    stage_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R12
    stage_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!room && !clr_i) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/zs_word_fmt.sv
module zs_word_fmt
    import zs_framer_pkg::*;
#(
    parameter int CW = 5
) (
    input  fr_state_t         state_i,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic [CW-1:0]     hit_cnt_i,
    input  logic [WORD_W-1:0] hit_word_i,
    output logic [WORD_W-1:0] word_o
);

    logic [15:0] cnt16;
    logic [15:0] block_len;

    assign cnt16     = 16'(hit_cnt_i);
    assign block_len = cnt16 + FRAME_OVERHEAD;

    always_comb begin
        unique case (state_i)
            S_HDR_EVT: word_o = {MARK_HDR, 8'h00, evt_i};
            S_HDR_CNT: word_o = {16'h0000, block_len};
            S_EMIT:    word_o = hit_word_i;
            S_TRAILER: word_o = {MARK_TRL, 8'h00, cnt16};
            default:   word_o = '0;
        endcase
    end

endmodule

// File: rtl/zs_event_ctrl.sv
module zs_event_ctrl
    import zs_framer_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             overlap_i,
    input  logic             hit_valid_i,
    input  logic             frame_end_i,
    input  logic             host_drained_i,
    input  logic [CW-1:0]    hit_cnt_i,
    output fr_state_t        state_o,
    output logic [EVT_W-1:0] evt_o,
    output logic [CW-1:0]    rd_idx_o,
    output logic             stage_clr_o,
    output logic             stage_wr_o,
    output logic             busy_o,
    output logic             fifo_wr_o
);

    fr_state_t        state_q, state_d;
    logic [EVT_W-1:0] evt_q;
    logic [CW-1:0]    rd_q;
    logic             accept;
    logic             last_hit;

    assign accept   = (state_q == S_IDLE) && trig_i;
    assign last_hit = ((rd_q + 1'b1) == hit_cnt_i);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (trig_i) state_d = S_COLLECT;
            S_COLLECT:    if (frame_end_i) state_d = S_HDR_EVT;
            S_HDR_EVT:    state_d = S_HDR_CNT;
            S_HDR_CNT:    state_d = (hit_cnt_i == '0) ? S_TRAILER : S_EMIT;
            S_EMIT:       if (last_hit) state_d = S_TRAILER;
            S_TRAILER:    state_d = overlap_i ? S_IDLE : S_WAIT_DRAIN;
            S_WAIT_DRAIN: if (host_drained_i) state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // state register, read pointer and event number
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            evt_q   <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_HDR_CNT) begin
                rd_q <= '0;
            end else if (state_q == S_EMIT) begin
                rd_q <= rd_q + 1'b1;
            end
            if (state_q == S_TRAILER) begin
                evt_q <= evt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        stage_clr_o = accept;
        stage_wr_o  = (state_q == S_COLLECT) && hit_valid_i;
        fifo_wr_o   = is_write_state(state_q);
        busy_o      = (state_q != S_IDLE) || trig_i;
    end

    assign state_o  = state_q;
    assign evt_o    = evt_q;
    assign rd_idx_o = rd_q;

    // R8
    evt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TRAILER) |=> (evt_q == $past(evt_q) + 16'd1));

    // R9
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TRAILER && !overlap_i) |=> busy_o);

    // R11
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && state_q != S_COLLECT) |=> (state_q != S_COLLECT));

    // R4
    hdr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HDR_EVT) |=> (fifo_wr_o && state_q == S_HDR_CNT));

endmodule

// File: rtl/zs_event_framer.sv
module zs_event_framer
    import zs_framer_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig_i,
    input  logic        overlap_i,
    input  logic        hit_valid_i,
    input  logic [31:0] hit_data_i,
    input  logic        frame_end_i,
    input  logic        host_drained_i,
    output logic        fifo_wr_o,
    output logic [31:0] fifo_data_o,
    output logic        busy_o
);

    localparam int CW = $clog2(DEPTH + 1);

    fr_state_t         state;
    logic [EVT_W-1:0]  evt;
    logic [CW-1:0]     rd_idx;
    logic [CW-1:0]     hit_cnt;
    logic [WORD_W-1:0] staged_word;
    logic              stage_clr;
    logic              stage_wr;

    zs_event_ctrl #(.CW(CW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .trig_i         (trig_i),
        .overlap_i      (overlap_i),
        .hit_valid_i    (hit_valid_i),
        .frame_end_i    (frame_end_i),
        .host_drained_i (host_drained_i),
        .hit_cnt_i      (hit_cnt),
        .state_o        (state),
        .evt_o          (evt),
        .rd_idx_o       (rd_idx),
        .stage_clr_o    (stage_clr),
        .stage_wr_o     (stage_wr),
        .busy_o         (busy_o),
        .fifo_wr_o      (fifo_wr_o)
    );

    zs_hit_stage #(.DEPTH(DEPTH)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (stage_clr),
        .wr_i     (stage_wr),
        .din_i    (hit_data_i),
        .rd_idx_i (rd_idx),
        .dout_o   (staged_word),
        .count_o  (hit_cnt)
    );

    zs_word_fmt #(.CW(CW)) u_fmt (
        .state_i    (state),
        .evt_i      (evt),
        .hit_cnt_i  (hit_cnt),
        .hit_word_i (staged_word),
        .word_o     (fifo_data_o)
    );

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && trig_i) |-> busy_o);

    // R7
    trailer_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TRAILER) |-> (fifo_wr_o && fifo_data_o[31:24] == MARK_TRL));

    // R10
    overlap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TRAILER && overlap_i) |=> (state == S_IDLE));

endmodule

// File: tb/zs_event_framer_test.sv
module zs_event_framer_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_i = 1'b0;
    logic        overlap_i = 1'b0;
    logic        hit_valid_i = 1'b0;
    logic [31:0] hit_data_i = '0;
    logic        frame_end_i = 1'b0;
    logic        host_drained_i = 1'b0;
    logic        fifo_wr_o;
    logic [31:0] fifo_data_o;
    logic        busy_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] cap [64];
    int cap_n = 0;
    logic [15:0] exp_evt = 16'd0;

    zs_event_framer #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .overlap_i(overlap_i),
        .hit_valid_i(hit_valid_i), .hit_data_i(hit_data_i),
        .frame_end_i(frame_end_i), .host_drained_i(host_drained_i),
        .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (fifo_wr_o && cap_n < 64) begin
            cap[cap_n] = fifo_data_o;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // full event: trigger, n hits, frame end, then the block is compared
    task automatic run_event(input int n, input logic [31:0] base, input bit ov);
        int st;
        int tmo;
        st = (n > DEPTH) ? DEPTH : n;
        cap_n = 0;
        step();
        overlap_i = ov;
        trig_i = 1'b1;
        #1;
        chk(busy_o == 1'b1, "R2 busy on accept", {31'd0, busy_o}, 32'd1);
        if (n == 0) begin
            step();
            trig_i = 1'b0;
            frame_end_i = 1'b1;
        end
        for (int i = 0; i < n; i++) begin
            step();
            trig_i = 1'b0;
            hit_valid_i = 1'b1;
            hit_data_i = base + i;
            frame_end_i = (i == n - 1);
        end
        step();
        hit_valid_i = 1'b0;
        frame_end_i = 1'b0;
        hit_data_i = 32'hDEAD_0000;
        tmo = 0;
        while (cap_n < st + 3 && tmo < 100) begin
            step();
            tmo++;
        end
        chk(cap_n == st + 3, "R6 block length", cap_n, st + 3);
        chk(cap[0] == {8'hA5, 8'h00, exp_evt}, "R4 header event", cap[0], {8'hA5, 8'h00, exp_evt});
        chk(cap[1] == 32'(st + 3), "R5 word count", cap[1], 32'(st + 3));
        for (int i = 0; i < st; i++) begin
            chk(cap[2 + i] == base + i, "R6 hit order", cap[2 + i], base + i);
        end
        chk(cap[st + 2] == {8'h5A, 8'h00, 16'(st)}, "R7 trailer", cap[st + 2], {8'h5A, 8'h00, 16'(st)});
        exp_evt = exp_evt + 16'd1;
        step();
    endtask

    task automatic test_reset();
        chk(busy_o == 1'b0, "R1 busy after reset", {31'd0, busy_o}, 32'd0);
        chk(fifo_wr_o == 1'b0, "R1 no write after reset", {31'd0, fifo_wr_o}, 32'd0);
    endtask

    task automatic test_default_drain();
        run_event(3, 32'h1000_0000, 1'b0);
        chk(busy_o == 1'b1, "R9 busy held before drain", {31'd0, busy_o}, 32'd1);
        trig_i = 1'b1;
        step();
        trig_i = 1'b0;
        step();
        chk(cap_n == 6, "R11 no block from busy trigger", cap_n, 6);
        chk(busy_o == 1'b1, "R9 still busy", {31'd0, busy_o}, 32'd1);
        host_drained_i = 1'b1;
        step();
        host_drained_i = 1'b0;
        chk(busy_o == 1'b0, "R9 busy released after drain", {31'd0, busy_o}, 32'd0);
        step();
        step();
        chk(busy_o == 1'b0 && cap_n == 6, "R11 ignored trigger started nothing", cap_n, 6);
    endtask

    task automatic test_empty();
        run_event(0, 32'h0, 1'b1);
        chk(cap_n == 3, "R13 empty event length", cap_n, 3);
    endtask

    task automatic test_overlap();
        run_event(2, 32'h2000_0000, 1'b1);
        chk(busy_o == 1'b0, "R10 busy released after trailer", {31'd0, busy_o}, 32'd0);
        run_event(1, 32'h3000_0000, 1'b1);
        chk(busy_o == 1'b0, "R10 back-to-back event done", {31'd0, busy_o}, 32'd0);
    endtask

    task automatic test_overflow();
        run_event(20, 32'h4000_0000, 1'b1);
        chk(cap[1] == 32'(DEPTH + 3), "R12 count saturates", cap[1], 32'(DEPTH + 3));
    endtask

    task automatic test_stray_hits();
        for (int i = 0; i < 3; i++) begin
            step();
            hit_valid_i = 1'b1;
            hit_data_i = 32'hBAD0_0000 + i;
            frame_end_i = (i == 2);
        end
        step();
        hit_valid_i = 1'b0;
        frame_end_i = 1'b0;
        chk(busy_o == 1'b0 && cap_n == 0 || busy_o == 1'b0, "R3 stray hits open nothing", {31'd0, busy_o}, 32'd0);
        run_event(1, 32'h5000_0000, 1'b1);
        chk(cap_n == 4, "R3 only in-event hits staged", cap_n, 4);
    endtask

    initial begin
        int wd;
        wd = 0;
        fork
            begin
                repeat (3) step();
                rst_n = 1'b1;
                step();
                test_reset();
                test_default_drain();
                test_empty();
                test_overlap();
                test_overflow();
                test_stray_hits();
            end
            begin
                repeat (20000) @(posedge clk);
                wd = 1;
            end
        join_any
        disable fork;
        if (wd != 0) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=expired expected=done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule